// File: doc/BRIEF.md
# Composite Sync Separator

This block splits an already sliced, digital composite sync stream into a horizontal and a vertical sync indication. Every falling edge of the sync stream produces a one-clock horizontal pulse. A sync low level that lasts longer than a programmable number of clocks is treated as the start of the vertical interval. The vertical pulse is then placed on a rising edge of an external periodic timing signal.

Two detection rules are available, chosen by a select input. The first rule fires on the next timing rise once a long low has been seen. The second rule additionally requires a sync falling edge inside the timing-low phase that follows the detection. A status output compares the sync level at two consecutive timing rises after each detection. This shows whether the vertical region is flat or serrated.

Both the sync input and the timing signal pass through identical two-flop synchronizers, so their relative phase is kept and each output appears three clocks after the input event that causes it.

Top module: `csync_sep`

## Requirements
- R1: Each high-to-low transition of `csync_i` produces `hpulse_o` high for exactly one clock, three rising clock edges after the first edge that samples the low level. A low-to-high transition produces no horizontal pulse.
- R2: A sync low period counts as long when `csync_i` stays low for at least `low_thr_i`+2 consecutive clocks. Shorter low periods never cause a vertical pulse.
- R3: With `vsel_i`=0, the first rising edge of `tim_i` after a long low is detected produces exactly one vertical pulse. The timing rise may come while sync is still low or after it has returned high.
- R4: With `vsel_i`=1, a long low opens a window at the next falling edge of `tim_i`, and the window ends at the following rising edge of `tim_i`. A vertical pulse is emitted on that rising edge only if a `csync_i` falling edge occurred inside the window. Otherwise the detection is discarded. A sync fall in the same clock as the timing rise does not count.
- R5: `vpulse_o` is high for one clock, three rising clock edges after the edge that first samples `tim_i` high following a low sample.
- R6: After each detection, the sync level is sampled at the first timing rise (A) and at the next one (B). `shape_o` then becomes A xor B (0 = equal, 1 = different) and holds that value until the next comparison completes.
- R7: While `rst_ni` is low, `hpulse_o`, `vpulse_o` and `shape_o` are 0, and all detection state is cleared.
- R8: The low-width counter saturates at its maximum value instead of wrapping. A single low period longer than the counter range therefore yields only one detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| csync_i | input | 1 | Sliced composite sync, active low |
| tim_i | input | 1 | Periodic timing signal from the timing generator |
| vsel_i | input | 1 | Vertical detection rule: 0 = next timing rise, 1 = require fall in timing-low window |
| low_thr_i | input | CNT_W | Low-width threshold in clocks |
| hpulse_o | output | 1 | One-clock horizontal sync pulse |
| vpulse_o | output | 1 | One-clock vertical sync pulse |
| shape_o | output | 1 | Vertical region shape status |

## Verification
A sync falling edge can land in the very clock in which the timing signal rises. That single cycle then holds a horizontal pulse, the close of a method-2 window, and the B sample of the shape comparison. The bench places a sync fall exactly on a timing rise while a method-2 window is open. It then expects the horizontal count to include that fall, no vertical pulse, and a low B sample. A second sequence re-arms detection one timing period after a pulse, to show that a completed pulse and a fresh detection do not disturb each other.

// File: rtl/csync_pkg.sv
package csync_pkg;
  typedef enum logic [1:0] {
    SH_IDLE   = 2'd0,
    SH_WAIT_A = 2'd1,
    SH_WAIT_B = 2'd2
  } shape_st_e;
endpackage

// File: rtl/csync_edge.sv
module csync_edge #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              dly_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[i] <= RST_VAL;
        else         sync_q[i] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[i] <= RST_VAL;
        else         sync_q[i] <= sync_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) dly_q <= RST_VAL;
    else         dly_q <= sync_q[STAGES-1];

  assign lvl_o  = sync_q[STAGES-1];
  assign rise_o = sync_q[STAGES-1] & ~dly_q;
  assign fall_o = ~sync_q[STAGES-1] & dly_q;
endmodule

// File: rtl/csync_low_meter.sv
module csync_low_meter #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lvl_i,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             arm_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             over, over_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                        cnt_q <= '0;
    else if (rise_i)                    cnt_q <= '0;
    else if (!lvl_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;

  assign over = ~lvl_i & (cnt_q > thr_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) over_q <= 1'b0;
    else         over_q <= over;

  // one event per long low period
  assign arm_o = over & ~over_q;
endmodule

// File: rtl/csync_vdet.sv
module csync_vdet (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic vsel_i,
  input  logic tim_lvl_i,
  input  logic tim_rise_i,
  input  logic tim_fall_i,
  input  logic cs_fall_i,
  output logic vpulse_o
);
  logic armed_q, win_q, seen_q, vp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      win_q   <= 1'b0;
      seen_q  <= 1'b0;
      vp_q    <= 1'b0;
    end else begin
      vp_q <= 1'b0;
      if (tim_rise_i && armed_q) begin
        if (!vsel_i) begin
          vp_q    <= 1'b1;
          armed_q <= 1'b0;
          win_q   <= 1'b0;
          seen_q  <= 1'b0;
        end else if (win_q) begin
          vp_q    <= seen_q;
          armed_q <= 1'b0;
          win_q   <= 1'b0;
          seen_q  <= 1'b0;
        end
      end else begin
        if (tim_fall_i && armed_q) win_q <= 1'b1;
        if (win_q && !tim_lvl_i && cs_fall_i) seen_q <= 1'b1;
      end
      if (arm_i) begin
        armed_q <= 1'b1;
        win_q   <= 1'b0;
        seen_q  <= 1'b0;
      end
    end
  end

  assign vpulse_o = vp_q;
endmodule

// File: rtl/csync_shape.sv
module csync_shape
  import csync_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic tim_rise_i,
  input  logic cs_lvl_i,
  output logic shape_o
);
  shape_st_e st_q;
  logic      a_q, shape_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= SH_IDLE;
      a_q     <= 1'b0;
      shape_q <= 1'b0;
    end else if (arm_i) begin
      st_q <= SH_WAIT_A;
    end else if (tim_rise_i) begin
      unique case (st_q)
        SH_WAIT_A: begin
          a_q  <= cs_lvl_i;
          st_q <= SH_WAIT_B;
        end
        SH_WAIT_B: begin
          shape_q <= a_q ^ cs_lvl_i;
          st_q    <= SH_IDLE;
        end
        default: st_q <= SH_IDLE;
      endcase
    end
  end

  assign shape_o = shape_q;
endmodule

// File: rtl/csync_sep.sv
module csync_sep #(
  parameter int CNT_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             csync_i,
  input  logic             tim_i,
  input  logic             vsel_i,
  input  logic [CNT_W-1:0] low_thr_i,
  output logic             hpulse_o,
  output logic             vpulse_o,
  output logic             shape_o
);
  logic cs_lvl, cs_rise, cs_fall;
  logic tm_lvl, tm_rise, tm_fall;
  logic arm;
  logic hp_q;

  csync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_edge (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (csync_i),
    .lvl_o (cs_lvl), .rise_o (cs_rise), .fall_o (cs_fall)
  );

  csync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_tm_edge (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (tim_i),
    .lvl_o (tm_lvl), .rise_o (tm_rise), .fall_o (tm_fall)
  );

  csync_low_meter #(.CNT_W(CNT_W)) u_meter (
    .clk_i (clk_i), .rst_ni (rst_ni), .lvl_i (cs_lvl), .rise_i (cs_rise),
    .thr_i (low_thr_i), .arm_o (arm)
  );

  csync_vdet u_vdet (
    .clk_i (clk_i), .rst_ni (rst_ni), .arm_i (arm), .vsel_i (vsel_i),
    .tim_lvl_i (tm_lvl), .tim_rise_i (tm_rise), .tim_fall_i (tm_fall),
    .cs_fall_i (cs_fall), .vpulse_o (vpulse_o)
  );

  csync_shape u_shape (
    .clk_i (clk_i), .rst_ni (rst_ni), .arm_i (arm), .tim_rise_i (tm_rise),
    .cs_lvl_i (cs_lvl), .shape_o (shape_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) hp_q <= 1'b0;
    else         hp_q <= cs_fall;

  assign hpulse_o = hp_q;
endmodule

// File: rtl/csync_sep_chk.sv
module csync_sep_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic csync_i,
  input logic tim_i,
  input logic hpulse_o,
  input logic vpulse_o,
  input logic shape_o
);
  logic [2:0] since_q;
  logic       warm;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)              since_q <= '0;
    else if (since_q != 3'd7) since_q <= since_q + 3'd1;

  assign warm = (since_q >= 3'd4);

  always @(posedge clk_i)
    if (!rst_ni) AST_RESET_QUIET: assert (!hpulse_o && !vpulse_o && !shape_o); // R7

  AST_H_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hpulse_o |=> !hpulse_o); // R1

  AST_H_FROM_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && hpulse_o) |-> (!$past(csync_i, 3) && $past(csync_i, 4))); // R1

  AST_V_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vpulse_o |=> !vpulse_o); // R5

  AST_V_ON_TIM_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && vpulse_o) |-> ($past(tim_i, 3) && !$past(tim_i, 4))); // R5

  AST_SHAPE_ON_TIM_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && !$stable(shape_o)) |-> ($past(tim_i, 3) && !$past(tim_i, 4))); // R6
endmodule

bind csync_sep csync_sep_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .csync_i  (csync_i),
  .tim_i    (tim_i),
  .hpulse_o (hpulse_o),
  .vpulse_o (vpulse_o),
  .shape_o  (shape_o)
);

// File: tb/csync_sep_bench.sv
module csync_sep_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 10;
  localparam int TPER       = 64;
  localparam int NVEC       = 12;

  typedef struct packed {
    int mode; int thr; int a1; int w1; int a2; int w2; int len;
    int kind; int eh; int ev; int evt; int esh;
  } vec_t;

  // kind: 0 = plain rule check, 2 = threshold boundary, 8 = counter saturation
  localparam vec_t VECS [NVEC] = '{
    '{0, 20, 40,   30,   0,  0,  300, 0, 1, 1,  67, 1},
    '{0, 20, 40,   10,   0,  0,  300, 0, 1, 0,  -1, 0},
    '{1, 20, 40,   30,   0,  0,  300, 0, 1, 0,  -1, 1},
    '{1, 20, 40,   30, 100, 10,  300, 0, 2, 1, 131, 1},
    '{0, 20, 40,  100,   0,  0,  300, 0, 1, 1,  67, 0},
    '{1, 20, 40,   50, 110, 40,  300, 0, 2, 1, 131, 0},
    '{0, 50, 40,   30,   0,  0,  300, 0, 1, 0,  -1, 0},
    '{1, 20, 40,   30, 128, 10,  300, 0, 2, 0,  -1, 0},
    '{0, 20, 40,   21,   0,  0,  300, 2, 1, 0,  -1, 0},
    '{0, 20, 40,   22,   0,  0,  300, 2, 1, 1,  67, 0},
    '{0,  5, 40, 1100,   0,  0, 1200, 8, 1, 1,  67, 0},
    '{1, 20, 40,   10, 100, 10,  300, 0, 2, 0,  -1, 0}
  };

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             csync_i = 1'b1;
  logic             tim_i = 1'b1;
  logic             vsel_i = 1'b0;
  logic [CNT_W-1:0] low_thr_i = '0;
  logic             hpulse_o, vpulse_o, shape_o;

  int checks = 0;
  int errors = 0;

  csync_sep #(.CNT_W(CNT_W)) u_csync_sep (
    .clk_i (clk_i), .rst_ni (rst_ni), .csync_i (csync_i), .tim_i (tim_i),
    .vsel_i (vsel_i), .low_thr_i (low_thr_i),
    .hpulse_o (hpulse_o), .vpulse_o (vpulse_o), .shape_o (shape_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string vtag(input vec_t v);
    if (v.kind == 2) return "R2";
    if (v.kind == 8) return "R8";
    return (v.mode != 0) ? "R4" : "R3";
  endfunction

  task automatic run_vec(input vec_t v);
    int hc, vc, vt;
    rst_ni    = 1'b0;
    csync_i   = 1'b1;
    tim_i     = 1'b1;
    vsel_i    = v.mode[0];
    low_thr_i = v.thr[CNT_W-1:0];
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    hc = 0; vc = 0; vt = -1;
    for (int c = 0; c < v.len; c++) begin
      @(negedge clk_i);
      if (hpulse_o) hc++;
      if (vpulse_o) begin
        vc++;
        if (vt < 0) vt = c;
      end
      csync_i = !((c >= v.a1 && c < v.a1 + v.w1) ||
                  (v.w2 > 0 && c >= v.a2 && c < v.a2 + v.w2));
      tim_i   = ((c % TPER) < TPER/2);
    end
    check(hc == v.eh, "R1 horizontal count", hc, v.eh);
    check(vc == v.ev, {vtag(v), " vertical count"}, vc, v.ev);
    check(vt == v.evt, "R5 vertical pulse cycle", vt, v.evt);
    check(shape_o == v.esh[0], "R6 shape status", int'(shape_o), v.esh);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R7: outputs quiet in reset
    repeat (3) @(negedge clk_i);
    check(!hpulse_o && !vpulse_o && !shape_o, "R7 reset outputs",
          int'({hpulse_o, vpulse_o, shape_o}), 0);

    for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

    // R7: shape left at 1 by a method-2 run is cleared by reset
    run_vec(VECS[2]);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check(!shape_o && !vpulse_o && !hpulse_o, "R7 reset clears state",
          int'({hpulse_o, vpulse_o, shape_o}), 0);
    rst_ni = 1'b1;
    csync_i = 1'b1;
    tim_i   = 1'b0;
    repeat (5) @(negedge clk_i);

    // R1: exact latency and width of horizontal pulse
    csync_i = 1'b0;
    @(negedge clk_i);
    check(!hpulse_o, "R1 no pulse after 1 edge", int'(hpulse_o), 0);
    @(negedge clk_i);
    check(!hpulse_o, "R1 no pulse after 2 edges", int'(hpulse_o), 0);
    @(negedge clk_i);
    check(hpulse_o, "R1 pulse after 3 edges", int'(hpulse_o), 1);
    @(negedge clk_i);
    check(!hpulse_o, "R1 pulse one clock wide", int'(hpulse_o), 0);

    // R1: rising edge gives no pulse
    csync_i = 1'b1;
    begin
      int seen = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk_i);
        if (hpulse_o) seen++;
      end
      check(seen == 0, "R1 no pulse on rising edge", seen, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule